// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the protection state of a serial flash device's status register and judges each decoded command against it. A command front end presents one command per cycle as a strobe with an operation code, a data byte for status writes and a byte address for program and erase operations. The block replies one cycle later with exactly one of two pulses, accept or reject. An accepted command updates the write enable latch, the block-protect field and the status-lock bit. A rejected command changes nothing. The current status byte is always visible on an output.

A three-state mode machine tracks the lock. The states are MODE_OPEN (lock bit clear), MODE_SOFT (lock bit set, write-protect pin high) and MODE_HARD (lock bit set, pin low).

Its transitions are:
- lock_set: MODE_OPEN to MODE_SOFT or MODE_HARD, taken when an accepted status write sets the lock bit. The pin level picks the target.
- pin_fall: MODE_SOFT to MODE_HARD.
- pin_rise: MODE_HARD to MODE_SOFT.
- lock_clear: MODE_SOFT or MODE_HARD to MODE_OPEN, taken when an accepted status write clears the bit. From MODE_HARD this is only possible once the pin is high.

While the pin is low and the lock bit is set, status writes are refused. This makes the block-protect field, and so the protected address range, fixed by hardware. The array is divided into 2^SECT_BITS sectors, and the block-protect code guards a run of sectors that ends at the top sector.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte is 0x00 (lock bit 0, block-protect 000, latch 0), and neither accept nor reject is asserted.
- R2: Operation codes 0 (latch set) and 1 (latch clear) are always accepted. They set or clear the write enable latch, which is status bit 1.
- R3: With the lock bit (status bit 7) at 0, a status write (code 2) is accepted if and only if the latch is set, at either pin level. When accepted, it loads bits 7 and 4:2 from the data byte.
- R4: With the lock bit at 1 and the write-protect pin high, a status write is accepted if and only if the latch is set.
- R5: With the lock bit at 1 and the pin low, every status write is rejected, and the status byte is left unchanged, even with the latch set.
- R6: The locked condition is reached in either order: by setting the lock bit while the pin is low, or by lowering the pin after the bit is set. Raising the pin makes status writes acceptable again.
- R7: Page program (code 3), sector erase (code 4) and page erase (code 6) are accepted only with the latch set and an address outside the protected sectors.
- R8: Bulk erase (code 5) is accepted only with the latch set and block-protect (status bits 4:2) equal to 000.
- R9: The protected sectors depend on the block-protect code B. Code 000 protects none. Code 111 protects all. Any other code protects the top min(2^B, sector count) sectors, where the sector is given by the top SECT_BITS address bits.
- R10: An accepted status write, program or erase clears the latch. A rejected command leaves the whole status byte unchanged.
- R11: Each strobed command yields, one cycle later, exactly one of accept or reject as a one-cycle pulse. A cycle without a strobe yields neither.
- R12: Operation code 7 is reserved and is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Operation code (0 latch set, 1 latch clear, 2 status write, 3 program, 4 sector erase, 5 bulk erase, 6 page erase, 7 reserved) |
| cmd_data | input | 8 | Data byte for status writes |
| cmd_addr | input | ADDR_W | Byte address for program and erase |
| wp_n | input | 1 | Active-low write-protect pin, sampled live |
| status_byte | output | 8 | {lock, 0, 0, block-protect[2:0], latch, 0} |
| cmd_accept | output | 1 | Pulse: previous cycle's command accepted |
| cmd_reject | output | 1 | Pulse: previous cycle's command rejected |

## Verification
Every result is due on the first rising edge after the strobe: the accept or reject pulse and the updated status byte both come from the same registers. The bench drives each command on a falling edge and computes the expected pulse and status byte from its own model of the protection rules, using the pin level applied with that command. It then compares the outputs 1 ns after the following rising edge, so each check covers exactly one register stage. A pin change takes effect for the command presented in the same cycle. Directed sequences cover both orders of entering the locked condition, and random runs cover everything else.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    typedef enum logic [2:0] {
        OP_LATCH_SET  = 3'd0,
        OP_LATCH_CLR  = 3'd1,
        OP_SR_WRITE   = 3'd2,
        OP_PROGRAM    = 3'd3,
        OP_SECT_ERASE = 3'd4,
        OP_BULK_ERASE = 3'd5,
        OP_PAGE_ERASE = 3'd6,
        OP_RESERVED   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        MODE_OPEN = 2'd0,
        MODE_SOFT = 2'd1,
        MODE_HARD = 2'd2
    } mode_e;

    localparam int BP_W        = 3;
    localparam int SR_LATCH    = 1;
    localparam int SR_BP_LO    = 2;
    localparam int SR_LOCK     = 7;

endpackage

// File: rtl/bp_zone_map.sv
module bp_zone_map #(
    parameter int SECT_BITS = 4
) (
    input  logic [flash_sr_pkg::BP_W-1:0] bp,
    input  logic [SECT_BITS-1:0]          sector,
    output logic                          zone_hit,
    output logic                          any_bp
);
    localparam int NSECT = 1 << SECT_BITS;
    localparam logic [flash_sr_pkg::BP_W-1:0] BP_ALL = '1;

    int guarded;

    always_comb begin
        if (bp == '0) begin
            guarded = 0;
        end else if (bp == BP_ALL) begin
            guarded = NSECT;
        end else begin
            guarded = 1 << bp;
            if (guarded > NSECT) begin
                guarded = NSECT;
            end
        end
    end

    // Guarded run always ends at the top sector.
    assign zone_hit = (guarded != 0) && (int'(sector) >= (NSECT - guarded));
    assign any_bp   = |bp;

endmodule

// File: rtl/prot_mode_fsm.sv
module prot_mode_fsm
    import flash_sr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wp_n,
    input  logic sr_commit,
    input  logic new_lock,
    output logic lock_bit,
    output logic sr_locked
);
    mode_e state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MODE_OPEN;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: lock_set, pin_fall, pin_rise, lock_clear
    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_OPEN: begin
                if (sr_commit && new_lock) begin
                    state_nx = wp_n ? MODE_SOFT : MODE_HARD;
                end
            end
            MODE_SOFT: begin
                if (sr_commit && !new_lock) begin
                    state_nx = MODE_OPEN;
                end else if (!wp_n) begin
                    state_nx = MODE_HARD;
                end
            end
            MODE_HARD: begin
                if (sr_commit && !new_lock) begin
                    state_nx = MODE_OPEN;
                end else if (wp_n) begin
                    state_nx = MODE_SOFT;
                end
            end
            default: state_nx = MODE_OPEN;
        endcase
    end

    // Outputs: lock bit and live refusal of status writes
    always_comb begin
        lock_bit  = (state != MODE_OPEN);
        sr_locked = lock_bit && !wp_n;
    end

    assert_hard_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_HARD && !wp_n) |=> (state == MODE_HARD));

    assert_hard_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_HARD && wp_n) |=> (state != MODE_HARD));

    assert_no_commit_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_bit && !wp_n) |-> !sr_commit);

endmodule

// File: rtl/cmd_judge.sv
module cmd_judge
    import flash_sr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  op_e             op,
    input  logic [BP_W-1:0] new_bp,
    input  logic            sr_locked,
    input  logic            zone_hit,
    input  logic            any_bp,
    output logic            latch,
    output logic [BP_W-1:0] bp,
    output logic            sr_commit,
    output logic            accept_q,
    output logic            reject_q
);
    logic allowed;
    logic take;

    always_comb begin
        allowed = 1'b0;
        unique case (op)
            OP_LATCH_SET, OP_LATCH_CLR:             allowed = 1'b1;
            OP_SR_WRITE:                            allowed = latch && !sr_locked;
            OP_PROGRAM, OP_SECT_ERASE,
            OP_PAGE_ERASE:                          allowed = latch && !zone_hit;
            OP_BULK_ERASE:                          allowed = latch && !any_bp;
            OP_RESERVED:                            allowed = 1'b0;
            default:                                allowed = 1'b0;
        endcase
    end

    assign take      = cmd_valid && allowed;
    assign sr_commit = take && (op == OP_SR_WRITE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch    <= 1'b0;
            bp       <= '0;
            accept_q <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            accept_q <= take;
            reject_q <= cmd_valid && !allowed;
            if (take) begin
                unique case (op)
                    OP_LATCH_SET: latch <= 1'b1;
                    OP_LATCH_CLR: latch <= 1'b0;
                    OP_SR_WRITE: begin
                        bp    <= new_bp;
                        latch <= 1'b0;
                    end
                    default:      latch <= 1'b0;
                endcase
            end
        end
    end

    assert_latch_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_LATCH_SET) |=> latch);

    assert_reserved_rej_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_RESERVED) |=> reject_q);

    assert_bulk_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_BULK_ERASE && any_bp) |=> !accept_q);

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
    import flash_sr_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int SECT_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_data,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wp_n,
    output logic [7:0]        status_byte,
    output logic              cmd_accept,
    output logic              cmd_reject
);
    op_e                  op_in;
    logic [SECT_BITS-1:0] sector;
    logic [BP_W-1:0]      bp;
    logic                 latch, lock_bit, sr_locked, sr_commit;
    logic                 zone_hit, any_bp;
    logic                 unused_bits;

    assign op_in       = op_e'(cmd_op);
    assign sector      = cmd_addr[ADDR_W-1 -: SECT_BITS];
    assign unused_bits = ^{cmd_addr[ADDR_W-SECT_BITS-1:0], cmd_data[6:5], cmd_data[1:0]};

    bp_zone_map #(.SECT_BITS(SECT_BITS)) u_zone (
        .bp       (bp),
        .sector   (sector),
        .zone_hit (zone_hit),
        .any_bp   (any_bp)
    );

    prot_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_n      (wp_n),
        .sr_commit (sr_commit),
        .new_lock  (cmd_data[SR_LOCK]),
        .lock_bit  (lock_bit),
        .sr_locked (sr_locked)
    );

    cmd_judge u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op        (op_in),
        .new_bp    (cmd_data[SR_BP_LO +: BP_W]),
        .sr_locked (sr_locked),
        .zone_hit  (zone_hit),
        .any_bp    (any_bp),
        .latch     (latch),
        .bp        (bp),
        .sr_commit (sr_commit),
        .accept_q  (cmd_accept),
        .reject_q  (cmd_reject)
    );

    assign status_byte = {lock_bit, 2'b00, bp, latch, 1'b0};

    assert_one_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject));

    assert_reply_due_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (cmd_accept || cmd_reject));

    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !(cmd_accept || cmd_reject));

    assert_reject_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> $stable(status_byte));

    assert_locked_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && status_byte[SR_LOCK]) |=> $stable(status_byte[7:2]));

endmodule

// File: tb/flash_sr_guard_test.sv
`timescale 1ns/1ps
module flash_sr_guard_test;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [7:0]        cmd_data = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              wp_n = 1'b1;
    logic [7:0]        status_byte;
    logic              cmd_accept, cmd_reject;

    int checks = 0;
    int errors = 0;

    bit       m_latch = 0;
    bit [2:0] m_bp = 0;
    bit       m_lock = 0;

    always #2.5 clk = ~clk;

    flash_sr_guard #(.ADDR_W(ADDR_W), .SECT_BITS(4)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_addr(cmd_addr), .wp_n(wp_n),
        .status_byte(status_byte), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
    );

    // R9 reference: protected top sectors for a block-protect code
    function automatic bit guarded(input bit [2:0] b, input logic [ADDR_W-1:0] a);
        int n;
        int s;
        s = int'(a[ADDR_W-1 -: 4]);
        if (b == 3'd0) return 1'b0;
        if (b == 3'd7) return 1'b1;
        n = 1 << b;
        if (n > 16) n = 16;
        return s >= 16 - n;
    endfunction

    function automatic bit allowed(input logic [2:0] op, input logic [ADDR_W-1:0] a, input bit wp);
        case (op)
            3'd0, 3'd1:       return 1'b1;
            3'd2:             return m_latch && !(m_lock && !wp);
            3'd3, 3'd4, 3'd6: return m_latch && !guarded(m_bp, a);
            3'd5:             return m_latch && (m_bp == 3'd0);
            default:          return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] model_status();
        return {m_lock, 2'b00, m_bp, m_latch, 1'b0};
    endfunction

    task automatic check(input string tag, input bit acc, input bit rej, input logic [7:0] st);
        checks++;
        if (cmd_accept !== acc || cmd_reject !== rej || status_byte !== st) begin
            errors++;
            $display("FAIL %s: acc/rej/status got %b/%b/%h expected %b/%b/%h",
                     tag, cmd_accept, cmd_reject, status_byte, acc, rej, st);
        end
    endtask

    task automatic step(input bit v, input logic [2:0] op, input logic [7:0] d,
                        input logic [ADDR_W-1:0] a, input bit wp, input string tag);
        bit ok;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_data = d; cmd_addr = a; wp_n = wp;
        ok = v && allowed(op, a, wp);
        if (ok) begin
            case (op)
                3'd0: m_latch = 1'b1;
                3'd1: m_latch = 1'b0;
                3'd2: begin m_lock = d[7]; m_bp = d[4:2]; m_latch = 1'b0; end
                default: m_latch = 1'b0;
            endcase
        end
        @(posedge clk);
        #1;
        check(tag, ok, v && !ok, model_status());
    endtask

    function automatic logic [ADDR_W-1:0] sect_addr(input int s);
        return ADDR_W'(s) << (ADDR_W - 4);
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0, 1'b0, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", 1'b0, 1'b0, 8'h00);

        step(1, 3'd2, 8'h9C, '0, 1, "R3 write without latch");
        step(1, 3'd0, 8'h00, '0, 1, "R2 latch set");
        step(1, 3'd1, 8'h00, '0, 1, "R2 latch clear");
        step(1, 3'd2, 8'h04, '0, 1, "R3 write after clear");
        step(0, 3'd0, 8'h00, '0, 1, "R11 idle cycle");
        step(1, 3'd0, 8'h00, '0, 0, "R2 latch set pin low");
        step(1, 3'd2, 8'h08, '0, 0, "R3 write pin low unlocked");
        // R6 order one: pin already low, then lock set
        step(1, 3'd0, 8'h00, '0, 0, "R2 latch set");
        step(1, 3'd2, 8'h8C, '0, 0, "R6 lock set with pin low");
        step(1, 3'd0, 8'h00, '0, 0, "R2 latch set while locked");
        step(1, 3'd2, 8'h00, '0, 0, "R5 write refused");
        step(1, 3'd2, 8'h1C, '0, 0, "R10 refused keeps status");
        step(1, 3'd2, 8'h84, '0, 1, "R6 pin raised write accepted");
        // R6 order two: lock set, then pin lowered
        step(1, 3'd0, 8'h00, '0, 1, "R2 latch set");
        step(1, 3'd2, 8'h00, '0, 0, "R6 pin lowered after lock");
        step(1, 3'd2, 8'h84, '0, 1, "R4 lock set pin high");
        // block-protect 001: sectors 14..15
        step(1, 3'd3, 8'h00, sect_addr(0), 1, "R7 program no latch");
        step(1, 3'd0, 8'h00, '0, 1, "R2 latch set");
        step(1, 3'd3, 8'h00, sect_addr(15), 1, "R7 program guarded");
        step(1, 3'd5, 8'h00, '0, 1, "R8 bulk with bp set");
        step(1, 3'd6, 8'h00, sect_addr(14), 1, "R7 page erase guarded");
        step(1, 3'd4, 8'h00, sect_addr(13), 1, "R10 sector erase clears latch");
        step(1, 3'd7, 8'h00, '0, 1, "R12 reserved");
        for (int b = 2; b < 8; b++) begin
            step(1, 3'd0, 8'h00, '0, 1, "R2 latch set");
            step(1, 3'd2, {1'b0, 2'b00, 3'(b), 2'b00}, '0, 1, "R9 set code");
            step(1, 3'd0, 8'h00, '0, 1, "R2 latch set");
            step(1, 3'd3, 8'h00, sect_addr(16 - (1 << (b > 4 ? 4 : b))), 1, "R9 lowest guarded");
            step(1, 3'd3, 8'h00, sect_addr(15 - (1 << (b > 4 ? 4 : b))), 1, "R9 just below");
        end
        step(1, 3'd0, 8'h00, '0, 1, "R2 latch set");
        step(1, 3'd2, 8'h00, '0, 1, "R3 clear protection");
        step(1, 3'd0, 8'h00, '0, 1, "R2 latch set");
        step(1, 3'd5, 8'h00, '0, 1, "R8 bulk with bp zero");

        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [2:0] op;
            r = int'($urandom_range(0, 9));
            op = (r >= 7) ? 3'd0 : 3'(r);
            if ($urandom_range(0, 15) == 0) op = 3'($urandom_range(0, 7));
            step($urandom_range(0, 9) != 0, op, 8'($urandom()), ADDR_W'($urandom()),
                 ($urandom_range(0, 3) != 0), "R11 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule